// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block paces the clock line of an I2C master. A prescaler turns the peripheral clock into an internal tick. A phase counter then measures out each SCL low phase and each SCL high phase in those ticks. The master engine asks for bit timing by holding a request input high. The generator drives SCL low for the low phase and then releases it. It waits until the sampled SCL line is actually high before it counts the high phase. The real rise time and any clock stretching by a slave therefore lengthen the period, and they never shorten the high time. Two one-cycle strobes mark the middle of the low phase, where the engine changes SDA, and the middle of the high phase, where it samples SDA.

Both divisors come from one packed configuration byte that software has already computed. A separate setup code can enable a fixed delay between SDA and SCL ahead of the first bit of a request. While the request input is low the generator stays idle and leaves SCL released.

Top module: `sclTimingGen`

## Requirements
- R1: The configuration byte holds the prescale field `cfgByte[DIV_W-1:0]` (value p) and the step field `cfgByte[DIV_W+5:DIV_W]` (value s, 0 to 63). DIV_W is a parameter, 2 or 3, with a default of 3. One internal tick lasts p+1 clock cycles, and every phase length in clock cycles equals its tick count times p+1.
- R2: Each low phase drives SCL low (`sclDriveLow`=1) for exactly (10+4s) ticks.
- R3: After the low phase, SCL is released. The high phase of (10+4s) ticks starts counting on the first cycle that `sclIn` is seen high. With an immediate rise, one bit from low start to the next low start lasts 2·(10+4s)·(p+1)+1 cycles.
- R4: While `sclIn` stays low after release, the high phase does not start. Each extra low cycle adds exactly one cycle to the bit.
- R5: `lowMidStrobe` pulses for one cycle at the end of tick number 5+2s of a low phase. `highMidStrobe` pulses for one cycle at the end of tick number 5+2s of a high phase, and only while SCL is released.
- R6: When `setupCode` equals 4'hF, a new request first keeps SCL released for 17 ticks, and the first low phase starts after that. With any other code, SCL goes low from the first clock edge that sees the request.
- R7: The setup delay is applied only before the first bit of a continuous request. While `bitReq` stays high, each high phase is followed directly by the next low phase.
- R8: One cycle after `bitReq` is seen low, SCL is released and both strobes stay quiet until a new request arrives, even if this happens in the middle of a bit.
- R9: While reset (`rstN` low) is asserted, SCL is released and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgByte | input | DIV_W+6 | Packed step and prescale fields |
| setupCode | input | 4 | First-bit setup enable code (4'hF enables it) |
| bitReq | input | 1 | Master engine requests bit timing |
| sclIn | input | 1 | Sampled level of the SCL line |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| lowMidStrobe | output | 1 | Middle of the low phase |
| highMidStrobe | output | 1 | Middle of the high phase |

## Verification
On every cycle the assertions check several properties. The tick never fires on two cycles in a row when the prescale value is non-zero. A dropped request releases the line on the next cycle and silences both strobes. The high phase is never entered while SCL reads low. A finished high phase goes straight into the next low phase when the request persists. The high strobe never appears while SCL is driven. The exact phase lengths, the strobe positions and the setup delay are absolute cycle counts that depend on the configuration. Only the bench sweep over prescale values, step values, stretch lengths and setup codes can show them, and it compares each one against arithmetic on the requirements.

// File: rtl/sclTimingPkg.sv
`timescale 1ns/1ps
package sclTimingPkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_LOW, PH_WAITHI, PH_HIGH
  } phase_e;

  // control -> datapath
  typedef struct packed {
    logic run;       // prescaler and tick counter active
    logic setupSel;  // counter limit is the setup length
  } dpCmd_t;

  // datapath -> control
  typedef struct packed {
    logic tick;
    logic atMid;
    logic atEnd;
  } dpStat_t;
endpackage

// File: rtl/sclTimingDp.sv
`timescale 1ns/1ps
module sclTimingDp
  import sclTimingPkg::*;
#(
  parameter int DIV_W       = 3,
  parameter int STEP_W      = 6,
  parameter int SETUP_TICKS = 17
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DIV_W+STEP_W-1:0] cfgByte,
  input  dpCmd_t                  cmd,
  output dpStat_t                 stat
);
  localparam int CFG_W     = DIV_W + STEP_W;
  localparam int CNT_W     = STEP_W + 3;
  localparam int BASE_HALF = 10;

  logic [DIV_W-1:0]  divSel;
  logic [STEP_W-1:0] stepSel;
  logic [CNT_W-1:0]  halfLen, midLen, limit;
  logic [DIV_W-1:0]  preCnt;
  logic [CNT_W-1:0]  tickCnt;

  assign divSel  = cfgByte[DIV_W-1:0];
  assign stepSel = cfgByte[CFG_W-1:DIV_W];
  // half period = (20 + 8*step) / 2
  assign halfLen = CNT_W'(BASE_HALF) + {1'b0, stepSel, 2'b00};
  assign midLen  = halfLen >> 1;
  assign limit   = cmd.setupSel ? CNT_W'(SETUP_TICKS) : halfLen;

  assign stat.tick  = cmd.run && (preCnt == divSel);
  assign stat.atEnd = (tickCnt == limit - CNT_W'(1));
  assign stat.atMid = (tickCnt == midLen - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            preCnt <= '0;
    else if (!cmd.run)    preCnt <= '0;
    else if (stat.tick)   preCnt <= '0;
    else                  preCnt <= preCnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        tickCnt <= '0;
    else if (!cmd.run)                tickCnt <= '0;
    else if (stat.tick && stat.atEnd) tickCnt <= '0;
    else if (stat.tick)               tickCnt <= tickCnt + CNT_W'(1);
  end

  // R1: with a non-zero prescale value, ticks are at least two cycles apart
  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stat.tick && divSel != '0) |=> (!stat.tick || !$stable(cfgByte)));
endmodule

// File: rtl/sclTimingCtrl.sv
`timescale 1ns/1ps
module sclTimingCtrl
  import sclTimingPkg::*;
#(
  parameter logic [3:0] SETUP_KEY = 4'hF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitReq,
  input  logic       sclIn,
  input  logic [3:0] setupCode,
  input  dpStat_t    stat,
  output dpCmd_t     cmd,
  output logic       sclDriveLow,
  output logic       lowMidStrobe,
  output logic       highMidStrobe
);
  phase_e state, nextState;
  logic   phaseDone;

  assign phaseDone = stat.tick && stat.atEnd;

  always_comb begin
    nextState = state;
    unique case (state)
      PH_IDLE:   if (bitReq) nextState = (setupCode == SETUP_KEY) ? PH_SETUP : PH_LOW;
      PH_SETUP:  if (phaseDone) nextState = PH_LOW;
      PH_LOW:    if (phaseDone) nextState = PH_WAITHI;
      PH_WAITHI: if (sclIn) nextState = PH_HIGH;
      PH_HIGH:   if (phaseDone) nextState = PH_LOW;
      default:   nextState = PH_IDLE;
    endcase
    if (!bitReq) nextState = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= nextState;
  end

  assign cmd.run      = (state == PH_SETUP) || (state == PH_LOW) || (state == PH_HIGH);
  assign cmd.setupSel = (state == PH_SETUP);

  assign sclDriveLow   = (state == PH_LOW);
  assign lowMidStrobe  = (state == PH_LOW)  && stat.tick && stat.atMid;
  assign highMidStrobe = (state == PH_HIGH) && stat.tick && stat.atMid;

  // R8: a dropped request releases the line and silences the strobes
  assert_release_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !bitReq |=> (!sclDriveLow && !lowMidStrobe && !highMidStrobe));

  // R4: the high phase never begins while the line still reads low
  assert_wait_scl_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_WAITHI && !sclIn) |=> (state != PH_HIGH));

  // R5: the sampling strobe only appears with SCL released
  assert_sample_released_R5: assert property (@(posedge clk) disable iff (!rstN)
    highMidStrobe |-> !sclDriveLow);

  // R7: a finished high phase under a held request goes straight to low
  assert_back_to_back_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_HIGH && phaseDone && bitReq) |=> sclDriveLow);
endmodule

// File: rtl/sclTimingGen.sv
`timescale 1ns/1ps
module sclTimingGen
  import sclTimingPkg::*;
#(
  parameter int         DIV_W       = 3,
  parameter int         STEP_W      = 6,
  parameter int         SETUP_TICKS = 17,
  parameter logic [3:0] SETUP_KEY   = 4'hF
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DIV_W+STEP_W-1:0] cfgByte,
  input  logic [3:0]              setupCode,
  input  logic                    bitReq,
  input  logic                    sclIn,
  output logic                    sclDriveLow,
  output logic                    lowMidStrobe,
  output logic                    highMidStrobe
);
  dpCmd_t  cmd;
  dpStat_t stat;

  sclTimingCtrl #(.SETUP_KEY(SETUP_KEY)) ctrl (
    .clk(clk), .rstN(rstN), .bitReq(bitReq), .sclIn(sclIn),
    .setupCode(setupCode), .stat(stat), .cmd(cmd),
    .sclDriveLow(sclDriveLow), .lowMidStrobe(lowMidStrobe),
    .highMidStrobe(highMidStrobe)
  );

  sclTimingDp #(.DIV_W(DIV_W), .STEP_W(STEP_W), .SETUP_TICKS(SETUP_TICKS)) dp (
    .clk(clk), .rstN(rstN), .cfgByte(cfgByte), .cmd(cmd), .stat(stat)
  );
endmodule

// File: tb/sclTimingGen_test.sv
`timescale 1ns/1ps
module sclTimingGen_test;
  localparam int DIV_W = 3;
  localparam int STEP_W = 6;
  localparam int CFG_W = DIV_W + STEP_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CFG_W-1:0] cfgByte = '0;
  logic [3:0] setupCode = 4'h0;
  logic bitReq = 1'b0;
  logic sclIn;
  logic sclDriveLow, lowMidStrobe, highMidStrobe;

  int checks = 0;
  int errors = 0;
  int relCnt = 0;
  int stretch = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // bus model: line rises `stretch` cycles after release
  always @(posedge clk) relCnt <= sclDriveLow ? 0 : ((relCnt < 100000) ? relCnt + 1 : relCnt);
  assign sclIn = !sclDriveLow && (relCnt >= stretch);

  sclTimingGen uut (
    .clk(clk), .rstN(rstN), .cfgByte(cfgByte), .setupCode(setupCode),
    .bitReq(bitReq), .sclIn(sclIn), .sclDriveLow(sclDriveLow),
    .lowMidStrobe(lowMidStrobe), .highMidStrobe(highMidStrobe)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runCase(int cdf, int scgd, int setupOn, int d);
    int c = cdf + 1;
    int h = 10 + 4 * scgd;
    int m = 5 + 2 * scgd;
    int k = 0;
    int t = 0;
    int tl = -1, tf = -1, th = -1, tr = -1;
    int quiet = 0;
    @(negedge clk);
    cfgByte = CFG_W'((scgd << DIV_W) | cdf);
    setupCode = setupOn ? 4'hF : 4'h7;
    stretch = d;
    bitReq = 1'b1;
    do begin
      @(negedge clk);
      k++;
    end while (!sclDriveLow && k < 5000);
    chk("R6 first low start", k, 1 + (setupOn ? 17 * c : 0));
    while (tr < 0 && t < 20000) begin
      @(negedge clk);
      t++;
      if (lowMidStrobe && tl < 0) tl = t;
      if (!sclDriveLow && tf < 0) tf = t;
      if (highMidStrobe && th < 0) th = t;
      if (sclDriveLow && tf >= 0 && tr < 0) tr = t;
    end
    chk("R5 low midpoint", tl, m * c - 1);
    chk("R1,R2 low length", tf, h * c);
    chk("R5 high midpoint", th, h * c + 1 + d + m * c - 1);
    if (d == 0) chk("R3 bit period", tr, 2 * h * c + 1);
    else        chk("R4 stretched period", tr, 2 * h * c + 1 + d);
    if (setupOn != 0) chk("R7 no setup between bits", tr, 2 * h * c + 1 + d);
    // abort in the middle of the second low phase
    @(negedge clk);
    bitReq = 1'b0;
    @(negedge clk);
    chk("R8 released after drop", int'(sclDriveLow), 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (sclDriveLow || lowMidStrobe || highMidStrobe) quiet++;
    end
    chk("R8 quiet while idle", quiet, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int sel = 0;
    int drops = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset drive", int'(sclDriveLow), 0);
    chk("R9 reset strobes", int'(lowMidStrobe | highMidStrobe), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int cdf = 0; cdf < 8; cdf++) begin
      for (int si = 0; si < 3; si++) begin
        for (int d = 0; d < 4; d += 2) begin
          runCase(cdf, (si == 0) ? 0 : ((si == 1) ? 1 : 4), sel % 2, d);
          sel++;
        end
      end
    end
    runCase(7, 63, 1, 5);
    runCase(0, 63, 0, 0);
    // drop request while waiting for a stretched rise: no high strobe afterwards
    @(negedge clk);
    cfgByte = CFG_W'((1 << DIV_W) | 1);
    setupCode = 4'h0;
    stretch = 50;
    bitReq = 1'b1;
    while (sclDriveLow !== 1'b1) @(negedge clk);
    while (sclDriveLow === 1'b1) @(negedge clk);
    repeat (5) @(negedge clk);
    bitReq = 1'b0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (sclDriveLow || highMidStrobe || lowMidStrobe) drops++;
    end
    chk("R8 drop during stretch", drops, 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule